// File: doc/BRIEF.md
# Decade Up/Down Counter with Separate Step Lines

This block is a single BCD digit that holds a value from 0 to 9. Two independent pulse lines move it. A rising edge on the up line adds one and a rising edge on the down line subtracts one. Neither line clocks any flop directly. Both are treated as asynchronous and pass through a synchroniser and a rising-edge detector that run on the one system clock. The counter register is then updated on that clock, so the design has a single clock domain and no dual-edge logic.

An active-high clear input acts at once, without waiting for a clock edge. It zeroes the digit and returns the synchronisers to a quiet state. A line that is already high when clear is released therefore does not produce a step.

The digit wraps at both ends. One-cycle carry and borrow strobes mark each wrap, so a neighbouring digit can be driven from them.

Top module: `bcd_updown_counter`

## Requirements
- R1: The digit output is a 4-bit binary-coded value and never leaves the range 0 to 9.
- R2: A low-to-high change on `upPulse` increments the digit by one. The new value is visible three system clock edges after the line rises: two synchroniser flops plus the counter register.
- R3: A low-to-high change on `downPulse` decrements the digit by one, with the same three-edge latency.
- R4: Stepping up from 9 gives 0. `carry` is high for exactly one cycle, the same cycle in which 0 first appears.
- R5: Stepping down from 0 gives 9. `borrow` is high for exactly one cycle, the same cycle in which 9 first appears.
- R6: If up and down edges are detected on the same system cycle, the digit is unchanged and neither strobe rises.
- R7: While `clr` is high, the digit reads 0 and both strobes read 0 at once, with no clock edge needed.
- R8: If a line is high when `clr` is released, it causes no step. A step requires that line to go low and then rise again.
- R9: A line held high for many cycles causes exactly one step. Counting depends on edges, not levels.
- R10: `carry` and `borrow` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous clear, active high |
| upPulse | input | 1 | Asynchronous increment line, rising edge counts |
| downPulse | input | 1 | Asynchronous decrement line, rising edge counts |
| digit | output | 4 | Current BCD value |
| carry | output | 1 | One-cycle strobe on a 9-to-0 wrap |
| borrow | output | 1 | One-cycle strobe on a 0-to-9 wrap |

## Verification
An up step and a down step can land on the same system cycle. The bench provokes this by raising both lines at the same instant, which expects an unchanged digit and silent strobes. It also raises them one cycle apart, which expects two separate opposite steps. The asynchronous clear can also meet a live step line. This is judged by releasing clear while the up line is held high and confirming the digit stays at 0 until a fresh rising edge arrives.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int DEF_DIGIT_MAX   = 9;

  // strobes from control to datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepReq_t;
endpackage

// File: rtl/pulse_sync.sv
module pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic lineIn,
  output logic rise
);
  logic [STAGES-1:0] syncQ;
  logic              prevQ;
  logic              lvl;

  assign lvl = syncQ[STAGES-1];

  // Reset to ones: a line already high at clear release looks "old", not a new edge.
  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      syncQ <= '1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], lineIn};
      prevQ <= lvl;
    end
  end

  assign rise = lvl & ~prevQ;
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl
  import bcd_ctr_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic     clk,
  input  logic     clr,
  input  logic     upLine,
  input  logic     downLine,
  output stepReq_t req
);
  localparam int N_CH = 2;

  logic [N_CH-1:0] lines;
  logic [N_CH-1:0] rises;

  assign lines = {downLine, upLine};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    pulse_sync #(.STAGES(SYNC_STAGES)) u_ps (
      .clk   (clk),
      .clr   (clr),
      .lineIn(lines[ch]),
      .rise  (rises[ch])
    );
  end

  // coincident requests cancel
  always_comb begin
    req.stepUp   = rises[0] & ~rises[1];
    req.stepDown = rises[1] & ~rises[0];
  end
endmodule

// File: rtl/digit_dp.sv
module digit_dp
  import bcd_ctr_pkg::*;
#(
  parameter int DIGIT_MAX = DEF_DIGIT_MAX,
  localparam int W = $clog2(DIGIT_MAX + 1)
) (
  input  logic         clk,
  input  logic         clr,
  input  stepReq_t     req,
  output logic [W-1:0] value,
  output logic         wrapUp,
  output logic         wrapDown
);
  localparam logic [W-1:0] TOPV = W'(DIGIT_MAX);

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      value    <= '0;
      wrapUp   <= 1'b0;
      wrapDown <= 1'b0;
    end else begin
      wrapUp   <= 1'b0;
      wrapDown <= 1'b0;
      if (req.stepUp) begin
        if (value == TOPV) begin
          value  <= '0;
          wrapUp <= 1'b1;
        end else begin
          value <= value + 1'b1;
        end
      end else if (req.stepDown) begin
        if (value == '0) begin
          value    <= TOPV;
          wrapDown <= 1'b1;
        end else begin
          value <= value - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_ctr_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int DIGIT_MAX   = DEF_DIGIT_MAX,
  localparam int DIGIT_W    = $clog2(DIGIT_MAX + 1)
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               upPulse,
  input  logic               downPulse,
  output logic [DIGIT_W-1:0] digit,
  output logic               carry,
  output logic               borrow
);
  stepReq_t stepReq;

  step_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .clr     (clr),
    .upLine  (upPulse),
    .downLine(downPulse),
    .req     (stepReq)
  );

  digit_dp #(.DIGIT_MAX(DIGIT_MAX)) u_dp (
    .clk     (clk),
    .clr     (clr),
    .req     (stepReq),
    .value   (digit),
    .wrapUp  (carry),
    .wrapDown(borrow)
  );
endmodule

// File: rtl/bcd_updown_checker.sv
module bcd_updown_checker (
  input logic       clk,
  input logic       clr,
  input logic [3:0] digit,
  input logic       carry,
  input logic       borrow
);
  a_r1_bcd_range: assert property (@(posedge clk) disable iff (clr)
    digit <= 4'd9);

  a_r4_carry_wrap: assert property (@(posedge clk) disable iff (clr)
    carry |-> (digit == 4'd0 && $past(digit) == 4'd9));

  a_r4_carry_single: assert property (@(posedge clk) disable iff (clr)
    carry |=> !carry);

  a_r5_borrow_wrap: assert property (@(posedge clk) disable iff (clr)
    borrow |-> (digit == 4'd9 && $past(digit) == 4'd0));

  a_r5_borrow_single: assert property (@(posedge clk) disable iff (clr)
    borrow |=> !borrow);

  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (clr)
    !(carry && borrow));

  // R2 / R3: any change is a single step modulo ten
  a_r2_single_step: assert property (@(posedge clk) disable iff (clr)
    !$stable(digit) |->
      (digit == (($past(digit) == 4'd9) ? 4'd0 : $past(digit) + 4'd1)) ||
      (digit == (($past(digit) == 4'd0) ? 4'd9 : $past(digit) - 4'd1)));
endmodule

bind bcd_updown_counter bcd_updown_checker u_chk (
  .clk   (clk),
  .clr   (clr),
  .digit (digit),
  .carry (carry),
  .borrow(borrow)
);

// File: tb/bcd_updown_counter_tb.sv
`timescale 1ns/1ps
module bcd_updown_counter_tb;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       upPulse = 1'b0;
  logic       downPulse = 1'b0;
  logic [3:0] digit;
  logic       carry;
  logic       borrow;

  int unsigned cyc = 0;
  int applied = 0;
  int failed = 0;
  bit finished = 0;
  int model = 0;

  typedef struct {
    int unsigned at;
    logic [3:0]  d;
    logic        c;
    logic        b;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd_updown_counter u_dut (
    .clk(clk), .clr(clr), .upPulse(upPulse), .downPulse(downPulse),
    .digit(digit), .carry(carry), .borrow(borrow)
  );

  task automatic compare(string tag, logic [3:0] ed, logic ec, logic eb);
    applied++;
    if (digit !== ed || carry !== ec || borrow !== eb) begin
      failed++;
      $display("FAIL %s: got digit=%0d carry=%b borrow=%b, expected digit=%0d carry=%b borrow=%b",
               tag, digit, carry, borrow, ed, ec, eb);
    end
  endtask

  // monitor: scoreboard pop
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at == cyc) begin
      exp_t e;
      e = q.pop_front();
      compare(e.tag, e.d, e.c, e.b);
    end
  end

  task automatic push(int unsigned at, int d, bit c, bit b, string tag);
    exp_t e;
    e.at = at; e.d = 4'(d); e.c = c; e.b = b; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: one pulse pattern, expected result pushed to scoreboard
  task automatic doStep(bit u, bit d, string tag);
    bit c = 0, b = 0;
    @(negedge clk);
    upPulse = u; downPulse = d;
    if (u && !d) begin
      c = (model == 9); model = (model == 9) ? 0 : model + 1;
    end else if (d && !u) begin
      b = (model == 0); model = (model == 0) ? 9 : model - 1;
    end
    push(cyc + 3, model, c, b, tag);
    push(cyc + 4, model, 0, 0, tag);
    repeat (3) @(negedge clk);
    upPulse = 0; downPulse = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    // R7: reset state while clear held
    repeat (3) @(negedge clk);
    compare("R7 reset state", 4'd0, 1'b0, 1'b0);
    clr = 0;
    repeat (3) @(negedge clk);
    compare("R8 no step after clear release", 4'd0, 1'b0, 1'b0);

    // R2 / R4: up through a wrap
    for (int i = 0; i < 12; i++) doStep(1, 0, (model == 9) ? "R4 carry wrap" : "R2 up step");
    // R3 / R5: down through a wrap
    for (int i = 0; i < 14; i++) doStep(0, 1, (model == 0) ? "R5 borrow wrap" : "R3 down step");

    // R6: coincident edges cancel
    doStep(1, 1, "R6 simultaneous");
    while (model != 9) doStep(1, 0, "R2 up step");
    doStep(1, 1, "R6 simultaneous at 9");
    doStep(1, 0, "R4 carry wrap");
    doStep(1, 1, "R6 simultaneous at 0");
    drain();

    // R6 contrast: edges one cycle apart both count
    @(negedge clk);
    upPulse = 1;
    push(cyc + 3, 1, 0, 0, "R6 offset up");
    @(negedge clk);
    downPulse = 1;
    push(cyc + 3, 0, 0, 0, "R6 offset down");
    repeat (4) @(negedge clk);
    upPulse = 0; downPulse = 0;
    drain();

    // R9: level held long gives one step
    @(negedge clk);
    upPulse = 1;
    model = 1;
    push(cyc + 3, 1, 0, 0, "R9 held level first");
    push(cyc + 12, 1, 0, 0, "R9 held level later");
    repeat (14) @(negedge clk);
    upPulse = 0;
    drain();

    // R7: clear mid-sequence, asynchronous
    doStep(1, 0, "R2 up step");
    drain();
    #1 clr = 1;
    #0.5 compare("R7 async clear", 4'd0, 1'b0, 1'b0);
    @(negedge clk);
    model = 0;

    // R8: up line high across clear release
    upPulse = 1;
    repeat (2) @(negedge clk);
    clr = 0;
    repeat (8) @(negedge clk);
    compare("R8 held line at release", 4'd0, 1'b0, 1'b0);
    upPulse = 0;
    repeat (4) @(negedge clk);
    doStep(1, 0, "R8 fresh edge after release");
    doStep(0, 1, "R3 down step");
    doStep(0, 1, "R5 borrow wrap");
    drain();

    if (q.size() != 0) begin
      failed++;
      $display("FAIL scoreboard: got %0d pending, expected 0", q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule